// File: doc/BRIEF.md
# Start/Done While-Loop Controller

This block sequences a child unit, the loop body, for as long as a one-bit loop condition holds. The parent sees a start/done handshake: `done_o` is high whenever the controller is idle, and a start is taken only then. The child sees the same kind of handshake from the other side. The controller sends it single-cycle start pulses and watches its done line to learn when an iteration has finished.

The loop condition is sampled at two moments only. The first is when the parent's start is accepted. The second is each time the body reports completion while the loop is running. If the condition is false at start, the body never runs and `done_o` stays high. If the condition is true at a completion, the body is started again. If it is false, the loop ends.

Two optional controls change the completion decision. A break request, raised in any cycle while the loop runs, is remembered and ends the loop at the next completion. A continue request, sampled at completion, restarts the body as if the condition were true. Each control can be removed with a parameter.

Top module: `loop_while_ctrl`

## Requirements
- R1: After reset `done_o` is 1 and `body_start_o` is 0.
- R2: `done_o` is low exactly while a loop is running. A `start_i` raised while `done_o` is low is ignored and adds no iteration.
- R3: A start accepted while `cond_i` is 1 gives `body_start_o` = 1 and `done_o` = 0 in the next cycle.
- R4: A start accepted while `cond_i` is 0 gives zero iterations. `done_o` stays 1 and no body start is issued.
- R5: `body_start_o` is a single-cycle pulse. After a pulse, no completion is recognised until `body_done_i` has first gone low.
- R6: At a body completion while running, `cond_i` = 1 produces a restart pulse in the next cycle, and `cond_i` = 0 makes `done_o` 1 in the next cycle. The number of iterations equals the number of true condition samples.
- R7: `brk_i` asserted in any cycle while running ends the loop at the next body completion, with no restart.
- R8: `cont_i` = 1 at a body completion restarts the body even when `cond_i` is 0.
- R9: A pending break takes priority over both `cond_i` and `cont_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Parent request to run the loop; accepted only while `done_o` is high |
| done_o | output | 1 | High while the controller is idle |
| cond_i | input | 1 | Loop condition, sampled at start and at each body completion |
| brk_i | input | 1 | Break request, remembered while the loop runs |
| cont_i | input | 1 | Continue request, sampled at body completion |
| body_start_o | output | 1 | Single-cycle start pulse to the body |
| body_done_i | input | 1 | Body idle/finished indication |

## Verification
The iteration count is the quantity to watch. A busy flag stuck high never lets `done_o` rise. A missed or early completion decision changes how many body start pulses are counted before `done_o` rises, and the difference shows within one body latency plus two cycles of the faulty decision. A break latch that fails to set or to clear shows up as an extra iteration in a break run, or as a one-iteration loop in the run after it. Each loop therefore ends with a comparison of the number of body pulses against the count of true condition samples, including runs with zero iterations.

// File: rtl/lc_pkg.sv
package lc_pkg;

  typedef enum logic [1:0] {
    DEC_IDLE  = 2'd0,
    DEC_AGAIN = 2'd1,
    DEC_EXIT  = 2'd2
  } lc_dec_e;

  // Completion decision: a pending break wins, then condition or continue.
  function automatic lc_dec_e lc_decide(input logic at_end,
                                        input logic pred,
                                        input logic cont,
                                        input logic brk);
    if (!at_end)           return DEC_IDLE;
    else if (brk)          return DEC_EXIT;
    else if (pred || cont) return DEC_AGAIN;
    else                   return DEC_EXIT;
  endfunction

endpackage

// File: rtl/lc_busy.sv
module lc_busy (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic busy_o
);
  logic busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     busy_q <= 1'b0;
    else if (set_i) busy_q <= 1'b1;
    else if (clr_i) busy_q <= 1'b0;
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/lc_kick.sv
module lc_kick (
  input  logic clk,
  input  logic rst_n,
  input  logic launch_i,
  input  logic body_done_i,
  output logic pulse_o,
  output logic pend_o
);
  logic fire_q;
  logic pend_q;

  // The pulse is registered, so it lasts exactly one cycle per launch.
  always_ff @(posedge clk) begin
    if (!rst_n) fire_q <= 1'b0;
    else        fire_q <= launch_i;
  end

  // The pending flag covers the gap until the child drops its done line.
  always_ff @(posedge clk) begin
    if (!rst_n)            pend_q <= 1'b0;
    else if (launch_i)     pend_q <= 1'b1;
    else if (!body_done_i) pend_q <= 1'b0;
  end

  assign pulse_o = fire_q;
  assign pend_o  = pend_q;
endmodule

// File: rtl/lc_brk_latch.sv
module lc_brk_latch #(
  parameter bit ENABLE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_i,
  input  logic brk_i,
  input  logic clr_i,
  output logic seen_o
);
  generate
    if (ENABLE) begin : g_brk
      logic hold_q;
      always_ff @(posedge clk) begin
        if (!rst_n)                hold_q <= 1'b0;
        else if (clr_i)            hold_q <= 1'b0;
        else if (busy_i && brk_i)  hold_q <= 1'b1;
      end
      assign seen_o = hold_q || (busy_i && brk_i);
    end else begin : g_nobrk
      logic unused_brk;
      assign unused_brk = &{1'b0, clk, rst_n, busy_i, brk_i, clr_i};
      assign seen_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/loop_while_ctrl.sv
module loop_while_ctrl #(
  parameter bit HAS_BREAK    = 1'b1,
  parameter bit HAS_CONTINUE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic done_o,
  input  logic cond_i,
  input  logic brk_i,
  input  logic cont_i,
  output logic body_start_o,
  input  logic body_done_i
);
  import lc_pkg::*;

  // Named internal events used by the checker.
  logic    busy_q;
  logic    pend_w;
  logic    accept_w;
  logic    go_first_w;
  logic    at_end_w;
  logic    cont_w;
  logic    brk_seen_w;
  lc_dec_e dec_w;
  logic    again_w;
  logic    exit_w;
  logic    launch_w;

  assign done_o     = !busy_q;
  assign accept_w   = start_i && !busy_q;
  assign go_first_w = accept_w && cond_i;
  assign at_end_w   = busy_q && body_done_i && !pend_w;

  generate
    if (HAS_CONTINUE) begin : g_cont
      assign cont_w = cont_i;
    end else begin : g_nocont
      logic unused_cont;
      assign unused_cont = cont_i;
      assign cont_w = 1'b0;
    end
  endgenerate

  assign dec_w    = lc_decide(at_end_w, cond_i, cont_w, brk_seen_w);
  assign again_w  = (dec_w == DEC_AGAIN);
  assign exit_w   = (dec_w == DEC_EXIT);
  assign launch_w = go_first_w || again_w;

  lc_busy u_busy (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (go_first_w),
    .clr_i  (exit_w),
    .busy_o (busy_q)
  );

  lc_kick u_kick (
    .clk         (clk),
    .rst_n       (rst_n),
    .launch_i    (launch_w),
    .body_done_i (body_done_i),
    .pulse_o     (body_start_o),
    .pend_o      (pend_w)
  );

  lc_brk_latch #(.ENABLE(HAS_BREAK)) u_brk (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy_i (busy_q),
    .brk_i  (brk_i),
    .clr_i  (exit_w),
    .seen_o (brk_seen_w)
  );
endmodule

// File: rtl/lc_while_chk.sv
module lc_while_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic done_o,
  input logic cond_i,
  input logic cont_i,
  input logic body_start_o,
  input logic at_end_w,
  input logic again_w,
  input logic exit_w,
  input logic brk_seen_w
);
  // R2
  hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_o && !at_end_w) |=> !done_o);

  // R2
  ignore_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !done_o && !at_end_w) |=> !body_start_o);

  // R3
  first_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && done_o && cond_i) |=> (body_start_o && !done_o));

  // R4
  zero_iter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && done_o && !cond_i) |=> (done_o && !body_start_o));

  // R5
  one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    body_start_o |=> !body_start_o);

  // R5
  no_early_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    body_start_o |-> !at_end_w);

  // R6
  again_chk: assert property (@(posedge clk) disable iff (!rst_n)
    again_w |=> (body_start_o && !done_o));

  // R6
  exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exit_w |=> (done_o && !body_start_o));

  // R7
  brk_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_end_w && brk_seen_w) |=> done_o);

  // R9
  brk_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_end_w && brk_seen_w && (cond_i || cont_i)) |=> !body_start_o);
endmodule

bind loop_while_ctrl lc_while_chk u_chk (.*);

// File: tb/tb_loop_while_ctrl.sv
module tb_loop_while_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic done_o;
  logic cond_i;
  logic brk_i;
  logic cont_i;
  logic body_start_o;
  logic body_done_i;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // Stimulus parameters for the running loop.
  int  limit   = 0;
  int  cont_to = 0;
  bit  cont_on = 1'b0;
  int  brk_at  = 0;
  bit  brk_on  = 1'b0;
  int  lat     = 1;
  bit  clr_cnt = 1'b0;
  int  starts  = 0;

  // Body stub state.
  logic sbusy = 1'b0;
  int   scnt  = 0;

  always #5 clk = ~clk;

  loop_while_ctrl dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .done_o       (done_o),
    .cond_i       (cond_i),
    .brk_i        (brk_i),
    .cont_i       (cont_i),
    .body_start_o (body_start_o),
    .body_done_i  (body_done_i)
  );

  // The condition is derived from the number of iterations already started.
  assign cond_i      = (starts < limit);
  assign cont_i      = cont_on && (starts < cont_to);
  assign brk_i       = brk_on && (starts == brk_at);
  assign body_done_i = !sbusy;

  always @(posedge clk) begin
    if (clr_cnt)           starts <= 0;
    else if (body_start_o) starts <= starts + 1;
  end

  // Counting body stub: busy for lat cycles after each start pulse.
  always @(posedge clk) begin
    if (!rst_n) begin
      sbusy <= 1'b0;
      scnt  <= 0;
    end else if (body_start_o) begin
      sbusy <= 1'b1;
      scnt  <= lat;
    end else if (sbusy) begin
      scnt <= scnt - 1;
      if (scnt <= 1) sbusy <= 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected iteration count, restated from the requirements.
  function automatic int exp_iters(int lim, bit con, int cto, bit bon, int bat);
    int n;
    if (lim == 0) return 0;
    n = lim;
    if (con && cto > n) n = cto;
    if (bon && bat >= 1 && bat < n) n = bat;
    return n;
  endfunction

  task automatic run_loop(int lim, bit con, int cto, bit bon, int bat, int blat, int poke);
    int exp;
    int waited;
    exp = exp_iters(lim, con, cto, bon, bat);
    @(negedge clk);
    clr_cnt = 1'b1;
    limit = lim; cont_on = con; cont_to = cto;
    brk_on = bon; brk_at = bat; lat = blat;
    @(negedge clk);
    clr_cnt = 1'b0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (lim > 0)
      check(body_start_o && !done_o, "R3 first pulse", {body_start_o, done_o}, 2);
    else
      check(done_o && !body_start_o, "R4 zero iterations idle", {body_start_o, done_o}, 1);
    waited = 0;
    while (!done_o && waited < 2000) begin
      @(negedge clk);
      start_i = (waited == poke) && !done_o;
      waited++;
    end
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    check(done_o, "R2 loop ends idle", done_o, 1);
    if (bon) check(starts == exp, "R7 break iteration count", starts, exp);
    else if (con) check(starts == exp, "R8 continue iteration count", starts, exp);
    else check(starts == exp, "R6 iterations equal true samples", starts, exp);
    brk_on = 1'b0; cont_on = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(done_o && !body_start_o, "R1 reset state", {body_start_o, done_o}, 1);

    // R4: false condition at start.
    run_loop(0, 1'b0, 0, 1'b0, 0, 2, -1);
    // R6: single and multiple iterations, shortest body.
    run_loop(1, 1'b0, 0, 1'b0, 0, 1, -1);
    run_loop(5, 1'b0, 0, 1'b0, 0, 1, -1);
    // R2: start raised while busy is ignored.
    run_loop(3, 1'b0, 0, 1'b0, 0, 3, 2);
    // R7: break in the middle of the run.
    run_loop(6, 1'b0, 0, 1'b1, 2, 2, -1);
    // R8: continue extends past the condition.
    run_loop(2, 1'b1, 5, 1'b0, 0, 2, -1);
    // R9: break wins over continue.
    run_loop(2, 1'b1, 6, 1'b1, 3, 1, -1);
    // R7: break on the first iteration.
    run_loop(4, 1'b0, 0, 1'b1, 1, 4, -1);

    for (int i = 0; i < 40; i++) begin
      int lim;
      int cto;
      int bat;
      int bl;
      int pk;
      bit con;
      bit bon;
      lim = $urandom_range(0, 6);
      con = 1'($urandom_range(0, 1));
      cto = $urandom_range(0, 8);
      bon = ($urandom_range(0, 3) == 0);
      bat = $urandom_range(1, 5);
      bl  = $urandom_range(1, 4);
      pk  = $urandom_range(0, 10);
      run_loop(lim, con, cto, bon, bat, bl, pk);
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule